// File: doc/BRIEF.md
# Mode-Selectable Program Fetch Router

This block sits between a processor core's instruction fetch stage and two program stores. One is on-chip flash with single-cycle reads. The other is an external memory bus with a request/ready handshake. Each fetch carries a 21-bit byte address in a 2-Mbyte linear program space. The router decides for every fetch, with no software help, whether the word comes from flash, from the external bus, or is a synthetic all-zero word. An all-zero word decodes as a no-operation.

A two-bit memory mode picks where the internal/external boundary lies. The mode is captured while reset is held and stays frozen afterwards. The flash size is a parameter, 48 KB (top address BFFFh) or 64 KB (top address FFFFh). The core issues one fetch at a time and gets a single fetch-valid pulse with the 16-bit word, whatever the source.

Top module: `prog_fetch_router`

## Requirements
- R1: While reset is held, and on the first cycle after it, fetch_valid, ext_req and flash_rd are all low.
- R2: With mode 00 (external only), every fetch, address 000000h included, goes to the external bus and flash_rd never rises.
- R3: With mode 01 (boot block), addresses up to 0007FFh read flash and addresses from 000800h upward use the external bus.
- R4: With mode 10 (extended), addresses up to the flash top (BFFFh for 48 KB, FFFFh for 64 KB) read flash and higher addresses use the external bus.
- R5: With mode 11 (internal only), a fetch above the flash top returns 0000h with fetch_valid one cycle after the accepted request. Neither ext_req nor flash_rd is raised for it.
- R6: A flash fetch raises flash_rd, with flash_addr equal to the low address bits, in the cycle the request is accepted. fetch_valid follows one cycle later, carrying flash_rdata.
- R7: An external fetch raises ext_req the cycle after acceptance, with ext_addr equal to the fetch address. ext_req and ext_addr hold until ext_ready is seen. fetch_valid then pulses for exactly one cycle, the cycle after ready, carrying the ext_rdata sampled with ready.
- R8: A request is accepted only while the router is idle. fetch_req held during an outstanding fetch starts no flash read or external access and produces no extra fetch_valid.
- R9: cfg_mode is sampled only while rst_n is low; changes to it after reset do not alter routing.
- R10: The reset vector 000000h and the interrupt vectors 000008h and 000018h come from flash in modes 01, 10 and 11 and from the external bus in mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; cfg_mode is captured while low |
| cfg_mode | input | 2 | Memory mode: 00 external, 01 boot block, 10 extended, 11 internal |
| fetch_req | input | 1 | Fetch request from the core |
| fetch_addr | input | 21 | Fetch byte address |
| fetch_valid | output | 1 | One-cycle pulse: fetch_data holds the fetched word |
| fetch_data | output | 16 | Fetched instruction word |
| flash_rd | output | 1 | Flash read strobe |
| flash_addr | output | 16 | Flash read address (log2 of flash size bits) |
| flash_rdata | input | 16 | Flash read data, valid the cycle after flash_rd |
| ext_req | output | 1 | External bus read request |
| ext_addr | output | 21 | External bus address |
| ext_ready | input | 1 | External bus data ready |
| ext_rdata | input | 16 | External bus read data, sampled with ext_ready |

## Verification
The assertions assume that ext_ready is raised only while ext_req is high. They also assume that flash_rdata is valid the cycle after flash_rd and that cfg_mode has settled before reset is released. The bench stays within these limits. A flash model answers only a strobed read. The external responder drives ready only after it has seen ext_req, and for one cycle only. Each mode change happens under a fresh reset, except for the deliberate change after reset that tests mode freezing.

// File: rtl/prog_fetch_router.sv
module prog_fetch_router #(
  parameter int FLASH_KB = 64,
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int BOOT_TOP = 'h7FF
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [1:0]                            cfg_mode,
  input  logic                                  fetch_req,
  input  logic [AW-1:0]                         fetch_addr,
  output logic                                  fetch_valid,
  output logic [DW-1:0]                         fetch_data,
  output logic                                  flash_rd,
  output logic [$clog2(FLASH_KB*1024)-1:0]      flash_addr,
  input  logic [DW-1:0]                         flash_rdata,
  output logic                                  ext_req,
  output logic [AW-1:0]                         ext_addr,
  input  logic                                  ext_ready,
  input  logic [DW-1:0]                         ext_rdata
);
  localparam int FLASH_BYTES = FLASH_KB * 1024;
  localparam int FAW = $clog2(FLASH_BYTES);
  localparam logic [AW-1:0] FLASH_TOP = AW'(FLASH_BYTES - 1);
  localparam logic [AW-1:0] BOOT_LIM = AW'(BOOT_TOP);

  typedef enum logic [2:0] {S_IDLE, S_FLASH, S_ZERO, S_EXT, S_XDONE} state_t;

  state_t        state;
  logic [1:0]    mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] ext_q;
  logic          accept, in_flash, to_ext;

  always_comb begin
    in_flash = 1'b0;
    to_ext   = 1'b0;
    case (mode_q)
      2'b00: to_ext = 1'b1;
      2'b01: begin
        in_flash = fetch_addr <= BOOT_LIM;
        to_ext   = !in_flash;
      end
      2'b10: begin
        in_flash = fetch_addr <= FLASH_TOP;
        to_ext   = !in_flash;
      end
      default: in_flash = fetch_addr <= FLASH_TOP;
    endcase
  end

  assign accept      = fetch_req && (state == S_IDLE);
  assign flash_rd    = accept && in_flash;
  assign flash_addr  = fetch_addr[FAW-1:0];
  assign ext_req     = (state == S_EXT);
  assign ext_addr    = addr_q;
  assign fetch_valid = (state == S_FLASH) || (state == S_ZERO) || (state == S_XDONE);
  assign fetch_data  = (state == S_FLASH) ? flash_rdata :
                       (state == S_XDONE) ? ext_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= cfg_mode;
      state  <= S_IDLE;
      addr_q <= '0;
      ext_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          addr_q <= fetch_addr;
          state  <= in_flash ? S_FLASH : (to_ext ? S_EXT : S_ZERO);
        end
        S_EXT: if (ext_ready) begin
          ext_q <= ext_rdata;
          state <= S_XDONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module prog_fetch_router_chk #(
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_q,
  input logic          fetch_valid,
  input logic          flash_rd,
  input logic          ext_req,
  input logic          ext_ready,
  input logic [AW-1:0] ext_addr
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !fetch_valid && !ext_req);

  p_no_flash_ext_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |-> !flash_rd);

  p_no_ext_internal_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11) |-> !ext_req);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> !fetch_valid);

  p_ext_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_ready |=> ext_req && $stable(ext_addr));

  p_ext_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && ext_ready |=> fetch_valid && !ext_req);

  p_one_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_rd && (ext_req || fetch_valid)));

  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));
endmodule

bind prog_fetch_router prog_fetch_router_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .fetch_valid(fetch_valid),
  .flash_rd(flash_rd), .ext_req(ext_req), .ext_ready(ext_ready), .ext_addr(ext_addr)
);

// File: tb/sim_prog_fetch_router.sv
`timescale 1ns/1ps
module sim_prog_fetch_router;
  localparam int KB = 48;
  localparam int K_FLASH = 0, K_EXT = 1, K_ZERO = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic        fetch_req = 1'b0;
  logic [20:0] fetch_addr = '0;
  logic        fetch_valid;
  logic [15:0] fetch_data;
  logic        flash_rd;
  logic [15:0] flash_addr;
  logic [15:0] flash_rdata = '0;
  logic        ext_req;
  logic [20:0] ext_addr;
  logic        ext_ready = 1'b0;
  logic [15:0] ext_rdata = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  prog_fetch_router #(.FLASH_KB(KB)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .flash_rd(flash_rd), .flash_addr(flash_addr), .flash_rdata(flash_rdata),
    .ext_req(ext_req), .ext_addr(ext_addr), .ext_ready(ext_ready), .ext_rdata(ext_rdata)
  );

  always @(posedge clk) if (flash_rd) flash_rdata <= flash_addr ^ 16'hA5A5;

  function automatic logic [15:0] ext_word(input logic [20:0] a);
    return a[15:0] ^ {11'd0, a[20:16]} ^ 16'h3C3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; cfg_mode = m; fetch_req = 1'b0; ext_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!fetch_valid && !ext_req && !flash_rd, "R1 quiet in reset", {fetch_valid, ext_req, flash_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fetch_valid && !ext_req && !flash_rd, "R1 quiet after reset", {fetch_valid, ext_req, flash_rd}, 0);
  endtask

  task automatic do_fetch(input logic [20:0] a, input int kind, input int dly, input string tag);
    int lat = 1, waits = 0;
    bit got = 0, saw_ext = 0, saw_fl;
    logic [15:0] d = '0, exp;
    exp = (kind == K_FLASH) ? (a[15:0] ^ 16'hA5A5) : (kind == K_EXT) ? ext_word(a) : 16'h0;
    @(negedge clk);
    fetch_addr = a; fetch_req = 1'b1;
    #1 saw_fl = flash_rd;
    if (kind == K_FLASH) chk(flash_addr == a[15:0], {tag, " R6 flash_addr"}, flash_addr, a[15:0]);
    @(negedge clk);
    fetch_req = 1'b0;
    for (int i = 0; i < 40 && !got; i++) begin
      if (fetch_valid) begin
        got = 1; d = fetch_data;
      end else begin
        if (ext_req) begin
          if (!saw_ext) chk(ext_addr == a, {tag, " R7 ext_addr"}, ext_addr, a);
          saw_ext = 1;
          if (waits == dly) begin ext_ready = 1'b1; ext_rdata = ext_word(ext_addr); end
          waits++;
        end
        @(negedge clk);
        ext_ready = 1'b0;
        lat++;
      end
    end
    chk(got, {tag, " valid seen"}, got, 1);
    chk(saw_fl == (kind == K_FLASH), {tag, " flash_rd use"}, saw_fl, kind == K_FLASH);
    chk(saw_ext == (kind == K_EXT), {tag, " ext_req use"}, saw_ext, kind == K_EXT);
    chk(lat == ((kind == K_EXT) ? dly + 2 : 1), {tag, " latency"}, lat, (kind == K_EXT) ? dly + 2 : 1);
    chk(d == exp, {tag, " data"}, d, exp);
    @(negedge clk);
    chk(!fetch_valid, {tag, " R7 single pulse"}, fetch_valid, 0);
  endtask

  task automatic test_busy_r8();
    logic [20:0] xa = 21'h1C0000;
    bit fl_seen = 0, got = 0, moved = 0;
    int waits = 0;
    do_reset(2'b10);
    @(negedge clk);
    fetch_addr = xa; fetch_req = 1'b1;
    @(negedge clk);
    fetch_addr = 21'h000010;
    for (int i = 0; i < 40 && !got; i++) begin
      #1;
      if (flash_rd) fl_seen = 1;
      if (fetch_valid) begin
        got = 1;
        fetch_req = 1'b0;
        chk(fetch_data == ext_word(xa), "R8 data of first fetch", fetch_data, ext_word(xa));
      end else begin
        if (ext_req) begin
          if (ext_addr != xa) moved = 1;
          if (waits == 4) begin ext_ready = 1'b1; ext_rdata = ext_word(ext_addr); end
          waits++;
        end
        @(negedge clk);
        ext_ready = 1'b0;
      end
    end
    chk(!fl_seen, "R8 held request ignored while busy", fl_seen, 0);
    chk(!moved, "R8 ext_addr unchanged", moved, 0);
    @(negedge clk);
    chk(!fetch_valid && !ext_req && !flash_rd, "R8 no extra fetch", {fetch_valid, ext_req, flash_rd}, 0);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(2'b00);
    do_fetch(21'h000000, K_EXT, 0, "R2 R10 mode00 reset vector");
    do_fetch(21'h000018, K_EXT, 3, "R2 R10 mode00 vector 18h");
    do_fetch(21'h1FFFFE, K_EXT, 1, "R2 mode00 top");

    do_reset(2'b01);
    do_fetch(21'h000000, K_FLASH, 0, "R3 R10 mode01 reset vector");
    do_fetch(21'h000008, K_FLASH, 0, "R10 mode01 vector 08h");
    do_fetch(21'h0007FF, K_FLASH, 0, "R3 R6 boot top");
    do_fetch(21'h000800, K_EXT, 2, "R3 R7 above boot");

    do_reset(2'b10);
    do_fetch(21'h000018, K_FLASH, 0, "R4 R10 mode10 vector 18h");
    do_fetch(21'h00BFFE, K_FLASH, 0, "R4 flash top");
    do_fetch(21'h00C000, K_EXT, 5, "R4 R7 above flash");

    do_reset(2'b11);
    do_fetch(21'h000008, K_FLASH, 0, "R10 mode11 vector 08h");
    do_fetch(21'h00BFFE, K_FLASH, 0, "R5 mode11 flash top");
    do_fetch(21'h00C000, K_ZERO, 0, "R5 zero fill above top");
    do_fetch(21'h1FFFFE, K_ZERO, 0, "R5 zero fill at space end");

    cfg_mode = 2'b00;
    do_fetch(21'h000000, K_FLASH, 0, "R9 mode change ignored low");
    do_fetch(21'h1F0000, K_ZERO, 0, "R9 mode change ignored high");

    test_busy_r8();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule